// File: doc/BRIEF.md
# Control Endpoint Stage Tracker with PING Handshake

This block follows a USB 2.0 control transfer on endpoint zero through its setup, data and status stages. It chooses the handshake for each event from the host. It takes decoded token events, a strobe for each good data packet from the host, a strobe for each IN packet the host acknowledged, a high-speed flag and a ready signal from the request handler. When the setup packet arrives, the block captures the transfer direction and the requested length. From then on it knows which stage is running.

At high speed the block answers PING tokens with ACK during the OUT data stage and the OUT status stage, whether or not the handler is ready. In every other stage, and at full or low speed, a PING gets no handshake. If the handler is not ready, flow control happens on the OUT data packet that follows, which is then refused with NAK.

For device-to-host transfers the block also sizes each IN packet and picks its data PID. Each packet carries at most the endpoint-zero maximum, and the reply is cut to the length the host asked for. All outputs are registered and appear one clock after the event that causes them.

Top module: `ep0_ping_stage`

## Requirements
- R1: While `hs_mode` is 0, a PING token (`tok_kind` 3) produces `hs_code` 0 (no handshake) in every stage.
- R2: At high speed, a PING in the OUT data stage (`stage` 2) produces `hs_code` 1 (ACK) one cycle later, even when `hdl_ready` is 0.
- R3: At high speed, a PING in the OUT status stage (`stage` 4) produces `hs_code` 1 (ACK).
- R4: A PING in the idle stage (0), the setup stage (1), the IN data stage (3) or the IN status stage (5) produces `hs_code` 0.
- R5: A data packet in the OUT data stage produces `hs_code` 1 when `hdl_ready` is 1 and `hs_code` 2 (NAK) when it is 0. The stage does not change.
- R6: A data packet in the setup stage is always answered with ACK. The next stage is then 5 when `setup_len` is 0, 3 when `setup_dir_in` is 1, and 2 otherwise.
- R7: In the IN data stage, an IN token with `hdl_ready` 1 sends a packet (`tx_valid` 1). Its length is the smaller of MAX_PKT (64) and the bytes remaining. The bytes remaining start at the smaller of `setup_len` and `reply_len`, and each `host_ack` deducts the length of the last packet. The first packet carries DATA1 (`tx_data1` 1), and the PID toggles after each `host_ack`.
- R8: An OUT token in the IN data stage moves to stage 4. An IN token in the OUT data stage moves to stage 5. In stage 5 an IN token sends a zero-length DATA1 packet, and a following `host_ack` returns to stage 0. In stage 4 an ACKed data packet returns to stage 0.
- R9: A SETUP token (`tok_kind` 0) in any stage moves to stage 1 and produces no handshake.
- R10: An IN token in stage 3 or 5 with `hdl_ready` 0 sends nothing and produces `hs_code` 2 (NAK).
- R11: After reset, `stage` is 0, `hs_code` is 0 and `tx_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_mode | input | 1 | 1 when the link runs at high speed |
| tok_valid | input | 1 | Token event strobe |
| tok_kind | input | 2 | Token type: 0 SETUP, 1 OUT, 2 IN, 3 PING |
| data_valid | input | 1 | Good data packet from the host received |
| setup_dir_in | input | 1 | Direction bit of the setup request, 1 = device to host |
| setup_len | input | LEN_W | Requested length from the setup request |
| reply_len | input | LEN_W | Bytes the handler has available for an IN reply |
| hdl_ready | input | 1 | Request handler can accept or supply data |
| host_ack | input | 1 | Host acknowledged the last IN packet |
| hs_code | output | 2 | Handshake to send: 0 none, 1 ACK, 2 NAK |
| tx_valid | output | 1 | Send a data packet |
| tx_len | output | PKT_W | Byte count of the packet to send |
| tx_data1 | output | 1 | 1 = DATA1 PID, 0 = DATA0 |
| stage | output | 3 | Current stage code |

## Verification
The bench sends PING in each of the six stages at both speeds and with the handler not ready. A design that ACKs PING during the setup stage or in an IN stage would show a non-zero `hs_code`. So would one that ignores the speed flag. A design that ties the PING answer to readiness would answer NAK. IN transfers are run with a request longer than the reply, with a request shorter than the reply, and with a request of zero length. These runs catch a wrong truncation, a packet above 64 bytes, a first PID of DATA0, and a zero-length request that wrongly enters a data stage. A SETUP token in the middle of a transfer checks that the abort is taken.

// File: rtl/ep0_ping_pkg.sv
package ep0_ping_pkg;

    typedef enum logic [1:0] {
        TK_SETUP = 2'd0,
        TK_OUT   = 2'd1,
        TK_IN    = 2'd2,
        TK_PING  = 2'd3
    } tok_e;

    typedef enum logic [1:0] {
        HS_NONE = 2'd0,
        HS_ACK  = 2'd1,
        HS_NAK  = 2'd2
    } hs_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_DOUT  = 3'd2,
        ST_DIN   = 3'd3,
        ST_SOUT  = 3'd4,
        ST_SIN   = 3'd5
    } stage_e;

    typedef struct packed {
        logic setup;
        logic out_t;
        logic in_t;
        logic ping;
    } tok_ev_t;

endpackage

// File: rtl/ep0_tok_decode.sv
module ep0_tok_decode
    import ep0_ping_pkg::*;
(
    input  logic       tok_valid,
    input  logic [1:0] tok_kind,
    output tok_ev_t    ev
);
    always_comb begin
        ev       = '0;
        ev.setup = tok_valid && (tok_kind == TK_SETUP);
        ev.out_t = tok_valid && (tok_kind == TK_OUT);
        ev.in_t  = tok_valid && (tok_kind == TK_IN);
        ev.ping  = tok_valid && (tok_kind == TK_PING);
    end
endmodule

// File: rtl/ep0_chunk_sizer.sv
module ep0_chunk_sizer #(
    parameter int LEN_W   = 16,
    parameter int MAX_PKT = 64,
    parameter int PKT_W   = 7
) (
    input  logic [LEN_W-1:0] remaining,
    output logic [PKT_W-1:0] chunk
);
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_PKT);

    always_comb begin
        if (remaining > MAX_L) chunk = PKT_W'(MAX_PKT);
        else                   chunk = remaining[PKT_W-1:0];
    end
endmodule

// File: rtl/ep0_ping_stage.sv
module ep0_ping_stage
    import ep0_ping_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int MAX_PKT = 64,
    localparam int PKT_W  = $clog2(MAX_PKT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_mode,
    input  logic             tok_valid,
    input  logic [1:0]       tok_kind,
    input  logic             data_valid,
    input  logic             setup_dir_in,
    input  logic [LEN_W-1:0] setup_len,
    input  logic [LEN_W-1:0] reply_len,
    input  logic             hdl_ready,
    input  logic             host_ack,
    output logic [1:0]       hs_code,
    output logic             tx_valid,
    output logic [PKT_W-1:0] tx_len,
    output logic             tx_data1,
    output logic [2:0]       stage
);

    typedef struct packed {
        stage_e           stage;
        logic [LEN_W-1:0] rem;
        logic             pid1;
        hs_e              hs;
        logic             tx_v;
        logic [PKT_W-1:0] tx_len;
        logic             tx_d1;
    } state_t;

    tok_ev_t          ev;
    logic [PKT_W-1:0] chunk;
    state_t           q, d;

    ep0_tok_decode u_dec (
        .tok_valid (tok_valid),
        .tok_kind  (tok_kind),
        .ev        (ev)
    );

    ep0_chunk_sizer #(
        .LEN_W   (LEN_W),
        .MAX_PKT (MAX_PKT),
        .PKT_W   (PKT_W)
    ) u_size (
        .remaining (q.rem),
        .chunk     (chunk)
    );

    always_comb begin
        d      = q;
        d.hs   = HS_NONE;
        d.tx_v = 1'b0;
        if (ev.setup) begin
            d.stage = ST_SETUP;
            d.rem   = '0;
        end else if (data_valid) begin
            unique case (q.stage)
                ST_SETUP: begin
                    d.hs   = HS_ACK;
                    d.pid1 = 1'b1;
                    d.rem  = (setup_len < reply_len) ? setup_len : reply_len;
                    if (setup_len == '0)   d.stage = ST_SIN;
                    else if (setup_dir_in) d.stage = ST_DIN;
                    else                   d.stage = ST_DOUT;
                end
                ST_DOUT: d.hs = hdl_ready ? HS_ACK : HS_NAK;
                ST_SOUT: begin
                    d.hs = hdl_ready ? HS_ACK : HS_NAK;
                    if (hdl_ready) d.stage = ST_IDLE;
                end
                default: ;
            endcase
        end else if (ev.ping) begin
            if (hs_mode && (q.stage == ST_DOUT || q.stage == ST_SOUT))
                d.hs = HS_ACK;
        end else if (ev.out_t) begin
            if (q.stage == ST_DIN) d.stage = ST_SOUT;
        end else if (ev.in_t) begin
            if (q.stage == ST_DIN) begin
                if (hdl_ready) begin
                    d.tx_v   = 1'b1;
                    d.tx_len = chunk;
                    d.tx_d1  = q.pid1;
                end else begin
                    d.hs = HS_NAK;
                end
            end else if (q.stage == ST_DOUT || q.stage == ST_SIN) begin
                d.stage = ST_SIN;
                if (hdl_ready) begin
                    d.tx_v   = 1'b1;
                    d.tx_len = '0;
                    d.tx_d1  = 1'b1;
                end else begin
                    d.hs = HS_NAK;
                end
            end
        end else if (host_ack) begin
            if (q.stage == ST_DIN) begin
                d.rem  = (q.rem > LEN_W'(q.tx_len)) ? q.rem - LEN_W'(q.tx_len) : '0;
                d.pid1 = ~q.pid1;
            end else if (q.stage == ST_SIN) begin
                d.stage = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{stage: ST_IDLE, rem: '0, pid1: 1'b1, hs: HS_NONE,
                   tx_v: 1'b0, tx_len: '0, tx_d1: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign hs_code  = q.hs;
    assign tx_valid = q.tx_v;
    assign tx_len   = q.tx_len;
    assign tx_data1 = q.tx_d1;
    assign stage    = q.stage;

    // R1
    ping_fs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.ping && !hs_mode && !data_valid) |=> (hs_code == HS_NONE));
    // R2
    ping_dout_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.ping && hs_mode && !data_valid && stage == ST_DOUT) |=> (hs_code == HS_ACK));
    // R3
    ping_sout_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.ping && hs_mode && !data_valid && stage == ST_SOUT) |=> (hs_code == HS_ACK));
    // R4
    ping_other_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.ping && !data_valid && stage != ST_DOUT && stage != ST_SOUT)
        |=> (hs_code == HS_NONE));
    // R6
    setup_pkt_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && !ev.setup && stage == ST_SETUP) |=> (hs_code == HS_ACK));
    // R7
    tx_len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_len <= PKT_W'(MAX_PKT)));
    // R8
    status_zlp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && stage == ST_SIN) |-> (tx_len == '0 && tx_data1));
    // R9
    setup_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev.setup |=> (stage == ST_SETUP && hs_code == HS_NONE));

endmodule

// File: tb/ep0_ping_stage_bench.sv
`timescale 1ns/1ps
module ep0_ping_stage_bench;
    localparam int LEN_W = 16;
    localparam int PKT_W = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs_mode = 1'b1, tok_valid = 1'b0, data_valid = 1'b0;
    logic [1:0] tok_kind = 2'd0;
    logic setup_dir_in = 1'b0, hdl_ready = 1'b1, host_ack = 1'b0;
    logic [LEN_W-1:0] setup_len = '0, reply_len = '0;
    logic [1:0] hs_code;
    logic tx_valid, tx_data1;
    logic [PKT_W-1:0] tx_len;
    logic [2:0] stage;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ep0_ping_stage u_ep0_ping_stage (
        .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode), .tok_valid(tok_valid),
        .tok_kind(tok_kind), .data_valid(data_valid), .setup_dir_in(setup_dir_in),
        .setup_len(setup_len), .reply_len(reply_len), .hdl_ready(hdl_ready),
        .host_ack(host_ack), .hs_code(hs_code), .tx_valid(tx_valid),
        .tx_len(tx_len), .tx_data1(tx_data1), .stage(stage)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Each event is one cycle wide; outputs are sampled at the next falling edge.
    task automatic tok(input logic [1:0] k);
        @(negedge clk); tok_valid = 1'b1; tok_kind = k;
        @(negedge clk); tok_valid = 1'b0;
    endtask

    task automatic pkt();
        @(negedge clk); data_valid = 1'b1;
        @(negedge clk); data_valid = 1'b0;
    endtask

    task automatic hack();
        @(negedge clk); host_ack = 1'b1;
        @(negedge clk); host_ack = 1'b0;
    endtask

    task automatic start(input logic dir_in, input int len, input int reply);
        setup_dir_in = dir_in; setup_len = LEN_W'(len); reply_len = LEN_W'(reply);
        tok(2'd0);
        chk("R9", "stage after SETUP", stage, 1);
        chk("R9", "hs after SETUP", hs_code, 0);
        pkt();
        chk("R6", "setup pkt hs", hs_code, 1);
    endtask

    task automatic t_reset();
        chk("R11", "stage", stage, 0);
        chk("R11", "hs", hs_code, 0);
        chk("R11", "tx_valid", tx_valid, 0);
        tok(2'd3);
        chk("R4", "ping idle", hs_code, 0);
    endtask

    task automatic t_out_xfer();
        start(1'b0, 8, 0);
        chk("R6", "out stage", stage, 2);
        tok(2'd3);
        chk("R2", "ping dout", hs_code, 1);
        hdl_ready = 1'b0;
        tok(2'd3);
        chk("R2", "ping dout not ready", hs_code, 1);
        tok(2'd1); pkt();
        chk("R5", "out data not ready", hs_code, 2);
        chk("R5", "stage kept", stage, 2);
        hdl_ready = 1'b1;
        pkt();
        chk("R5", "out data ready", hs_code, 1);
        hs_mode = 1'b0;
        tok(2'd3);
        chk("R1", "ping full speed", hs_code, 0);
        hs_mode = 1'b1;
        tok(2'd2);
        chk("R8", "stage to status in", stage, 5);
        chk("R8", "zlp valid", tx_valid, 1);
        chk("R8", "zlp len", tx_len, 0);
        chk("R8", "zlp pid", tx_data1, 1);
        tok(2'd3);
        chk("R4", "ping status in", hs_code, 0);
        hack();
        chk("R8", "idle after status", stage, 0);
    endtask

    task automatic t_setup_ping();
        tok(2'd0);
        tok(2'd3);
        chk("R4", "ping setup stage", hs_code, 0);
    endtask

    task automatic t_in_long();
        start(1'b1, 100, 150);
        chk("R6", "in stage", stage, 3);
        tok(2'd2);
        chk("R7", "pkt1 valid", tx_valid, 1);
        chk("R7", "pkt1 len", tx_len, 64);
        chk("R7", "pkt1 pid", tx_data1, 1);
        hack();
        tok(2'd3);
        chk("R4", "ping din", hs_code, 0);
        hdl_ready = 1'b0;
        tok(2'd2);
        chk("R10", "in not ready hs", hs_code, 2);
        chk("R10", "in not ready tx", tx_valid, 0);
        hdl_ready = 1'b1;
        tok(2'd2);
        chk("R7", "pkt2 len", tx_len, 36);
        chk("R7", "pkt2 pid", tx_data1, 0);
        hack();
        tok(2'd1);
        chk("R8", "stage status out", stage, 4);
        tok(2'd3);
        chk("R3", "ping sout", hs_code, 1);
        hs_mode = 1'b0;
        tok(2'd3);
        chk("R1", "ping sout full speed", hs_code, 0);
        hs_mode = 1'b1;
        pkt();
        chk("R8", "status out hs", hs_code, 1);
        chk("R8", "idle after status out", stage, 0);
    endtask

    task automatic t_in_trunc();
        start(1'b1, 200, 20);
        tok(2'd2);
        chk("R7", "truncated len", tx_len, 20);
        chk("R7", "truncated pid", tx_data1, 1);
        tok(2'd0);
        chk("R9", "abort in data", stage, 1);
    endtask

    task automatic t_zero_len();
        start(1'b1, 0, 30);
        chk("R6", "zero length stage", stage, 5);
        tok(2'd3);
        chk("R4", "ping zero status", hs_code, 0);
        hdl_ready = 1'b0;
        tok(2'd2);
        chk("R10", "status in not ready", hs_code, 2);
        hdl_ready = 1'b1;
        tok(2'd2);
        chk("R8", "status zlp len", tx_len, 0);
        chk("R8", "status zlp pid", tx_data1, 1);
        hack();
        chk("R8", "idle", stage, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_out_xfer();
        t_setup_ping();
        t_in_long();
        t_in_trunc();
        t_zero_len();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule